// File: doc/BRIEF.md
# Digital Clock Time-Setting Key Controller

This block keeps the time of day for a 24-hour clock as three two-digit BCD fields (hours, minutes, seconds) and lets a user set it with three pushbuttons, one per field. Raw key levels are sampled on a slow scan strobe, a few tens of hertz, and are accepted only when consecutive samples agree. That filtering removes contact bounce without a per-key counter.

Pressing a key steps its field once. Keeping it pressed makes the field advance again on each 8 Hz strobe, starting one full repeat period after the first step. A field being set wraps inside its own range and never carries into the next field. While no key is held, a 1 Hz strobe runs the clock normally, with carries from seconds to minutes to hours.

All strobes are single-cycle enables in the system clock domain. Reset is synchronous and active high.

Top module: `clock_set_keys`

## Requirements
- R1: A synchronous active-high reset sets the time to 00:00:00 and clears all key filtering state, so no step pulse follows reset until a key is newly accepted.
- R2: Every field holds two BCD digits (tens in bits 7:4, units in bits 3:0). Seconds and minutes stay within 00..59 and hours within 00..23.
- R3: When no key is accepted as held, each `tick_1hz` advances seconds by one, carries 59→00 into minutes, and carries 59:59→00:00 into hours. Hours wrap from 23 to 00.
- R4: A key is accepted as pressed only after two consecutive scan samples read it high, and as released only after two consecutive samples read it low. A key level seen by only one scan sample changes nothing.
- R5: A press that is accepted and then released before the second following `tick_8hz` advances its field by exactly one.
- R6: While a key stays accepted, the first `tick_8hz` after the press only arms the repeat. Every later `tick_8hz` advances the field by one.
- R7: A field advanced by its key wraps within its own range (59→00 or 23→00) and leaves the other fields unchanged.
- R8: The three keys act independently. Keys pressed together step their own fields in the same cycle.
- R9: While any key is accepted as held, `tick_1hz` has no effect on the time.
- R10: `adj_step` pulses for one cycle in each cycle in which a key steps its field. Bit 0 is seconds, bit 1 is minutes and bit 2 is hours.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle strobe, once per second |
| tick_8hz | input | 1 | One-cycle auto-repeat strobe |
| tick_scan | input | 1 | One-cycle key sampling strobe (tens of Hz) |
| key_sec | input | 1 | Raw seconds-set key, high when pressed |
| key_min | input | 1 | Raw minutes-set key, high when pressed |
| key_hr | input | 1 | Raw hours-set key, high when pressed |
| adj_step | output | 3 | Per-field step pulses {hr, min, sec} |
| sec_bcd | output | 8 | Seconds, two BCD digits |
| min_bcd | output | 8 | Minutes, two BCD digits |
| hr_bcd | output | 8 | Hours, two BCD digits |

## Verification
Several properties are checked every cycle: the digit ranges, the zero state after reset, the rule that the time only moves in a cycle with a 1 Hz strobe or a step pulse, and the rule that a step of seconds or minutes leaves the higher fields untouched. The bench's scenarios are needed for the rest. These are the two-sample filtering of a one-scan glitch, the exact step count of a short tap, the arm-then-repeat timing of a held key, the blocking of the 1 Hz strobe during a hold, and the full 23:59:59 rollover. A behavioural model compares the bench's results on every clock.

// File: rtl/clock_set_keys.sv
module clock_set_keys #(
  parameter int DEB_DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_1hz,
  input  logic       tick_8hz,
  input  logic       tick_scan,
  input  logic       key_sec,
  input  logic       key_min,
  input  logic       key_hr,
  output logic [2:0] adj_step,
  output logic [7:0] sec_bcd,
  output logic [7:0] min_bcd,
  output logic [7:0] hr_bcd
);
  localparam int NK = 3;

  logic [NK-1:0] raw, held, held_q, armed;
  logic [DEB_DEPTH-1:0] samp [NK];
  logic [7:0] sec_r, min_r, hr_r;
  logic run, sec_wrap, min_wrap;

  assign raw = {key_hr, key_min, key_sec};

  function automatic logic [7:0] bump(input logic [7:0] v, input logic [3:0] tmax, input logic [3:0] umax);
    if (v == {tmax, umax})   bump = 8'h00;
    else if (v[3:0] == 4'd9) bump = {v[7:4] + 4'd1, 4'd0};
    else                     bump = {v[7:4], v[3:0] + 4'd1};
  endfunction

  for (genvar i = 0; i < NK; i++) begin : g_key
    always_ff @(posedge clk) begin
      if (rst) begin
        samp[i]   <= '0;
        held[i]   <= 1'b0;
        held_q[i] <= 1'b0;
        armed[i]  <= 1'b0;
      end else begin
        if (tick_scan) samp[i] <= {samp[i][DEB_DEPTH-2:0], raw[i]};
        if (&samp[i])       held[i] <= 1'b1;
        else if (~|samp[i]) held[i] <= 1'b0;
        held_q[i] <= held[i];
        if (held[i] && !held_q[i])   armed[i] <= 1'b0;
        else if (held[i] && tick_8hz) armed[i] <= 1'b1;
      end
    end
    assign adj_step[i] = held[i] && (!held_q[i] || (tick_8hz && armed[i]));
  end

  assign run      = tick_1hz && !(|held);
  assign sec_wrap = sec_r == 8'h59;
  assign min_wrap = min_r == 8'h59;

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_r <= 8'h00;
      min_r <= 8'h00;
      hr_r  <= 8'h00;
    end else begin
      if (adj_step[0] || run) sec_r <= bump(sec_r, 4'd5, 4'd9);
      if (adj_step[1] || (run && sec_wrap)) min_r <= bump(min_r, 4'd5, 4'd9);
      if (adj_step[2] || (run && sec_wrap && min_wrap)) hr_r <= bump(hr_r, 4'd2, 4'd3);
    end
  end

  assign sec_bcd = sec_r;
  assign min_bcd = min_r;
  assign hr_bcd  = hr_r;
endmodule

// File: rtl/clock_set_keys_chk.sv
module clock_set_keys_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick_1hz,
  input logic [2:0] adj_step,
  input logic [7:0] sec_bcd,
  input logic [7:0] min_bcd,
  input logic [7:0] hr_bcd
);
  AST_RESET_ZERO: assert property (@(posedge clk) rst |=> (sec_bcd == 8'h00 && min_bcd == 8'h00 && hr_bcd == 8'h00 && adj_step == 3'b000)); // R1
  AST_MS_RANGE: assert property (@(posedge clk) disable iff (rst) (sec_bcd[3:0] <= 4'd9 && sec_bcd[7:4] <= 4'd5 && min_bcd[3:0] <= 4'd9 && min_bcd[7:4] <= 4'd5)); // R2
  AST_HR_RANGE: assert property (@(posedge clk) disable iff (rst) (hr_bcd[3:0] <= 4'd9 && (hr_bcd[7:4] < 4'd2 || (hr_bcd[7:4] == 4'd2 && hr_bcd[3:0] <= 4'd3)))); // R2
  AST_IDLE_STILL: assert property (@(posedge clk) disable iff (rst) (!tick_1hz && adj_step == 3'b000) |=> ($stable(sec_bcd) && $stable(min_bcd) && $stable(hr_bcd))); // R3
  AST_SEC_NO_CARRY: assert property (@(posedge clk) disable iff (rst) (adj_step == 3'b001) |=> ($stable(min_bcd) && $stable(hr_bcd))); // R7
  AST_MIN_NO_CARRY: assert property (@(posedge clk) disable iff (rst) (adj_step == 3'b010) |=> ($stable(hr_bcd) && $stable(sec_bcd))); // R7
endmodule

bind clock_set_keys clock_set_keys_chk chk_i (
  .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .adj_step(adj_step),
  .sec_bcd(sec_bcd), .min_bcd(min_bcd), .hr_bcd(hr_bcd)
);

// File: tb/clock_set_keys_tb.sv
module clock_set_keys_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic tick_1hz = 0, tick_8hz = 0, tick_scan = 0;
  logic key_sec = 0, key_min = 0, key_hr = 0;
  logic [2:0] adj_step;
  logic [7:0] sec_bcd, min_bcd, hr_bcd;

  clock_set_keys dut_i (
    .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .tick_8hz(tick_8hz), .tick_scan(tick_scan),
    .key_sec(key_sec), .key_min(key_min), .key_hr(key_hr),
    .adj_step(adj_step), .sec_bcd(sec_bcd), .min_bcd(min_bcd), .hr_bcd(hr_bcd)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0, errors = 0, cyc = 0;
  string req = "R1";
  int m_sec = 0, m_min = 0, m_hr = 0;
  int s_new[3], s_old[3], pressed[3], pressed_d[3], rep_ok[3];

  function automatic logic [7:0] to_bcd(int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  task automatic model_clear();
    m_sec = 0; m_min = 0; m_hr = 0;
    for (int i = 0; i < 3; i++) begin
      s_new[i] = 0; s_old[i] = 0; pressed[i] = 0; pressed_d[i] = 0; rep_ok[i] = 0;
    end
  endtask

  task automatic cyc_once(input logic [2:0] k, input logic sc, input logic t8, input logic t1);
    int st[3];
    int any_held, ks[3], nxt;
    @(negedge clk);
    key_sec = k[0]; key_min = k[1]; key_hr = k[2];
    tick_scan = sc; tick_8hz = t8; tick_1hz = t1;
    #1;
    ks[0] = k[0]; ks[1] = k[1]; ks[2] = k[2];
    any_held = 0;
    for (int i = 0; i < 3; i++) begin
      st[i] = (pressed[i] != 0 && (pressed_d[i] == 0 || (t8 && rep_ok[i] != 0))) ? 1 : 0;
      if (pressed[i] != 0) any_held = 1;
    end
    vectors++;
    if (adj_step !== {st[2][0], st[1][0], st[0][0]} || sec_bcd !== to_bcd(m_sec) ||
        min_bcd !== to_bcd(m_min) || hr_bcd !== to_bcd(m_hr)) begin
      errors++;
      $display("FAIL %s cyc %0d: act step=%b %h:%h:%h exp step=%b %h:%h:%h", req, cyc,
               adj_step, hr_bcd, min_bcd, sec_bcd, {st[2][0], st[1][0], st[0][0]},
               to_bcd(m_hr), to_bcd(m_min), to_bcd(m_sec));
    end
    if (st[0] != 0 || st[1] != 0 || st[2] != 0) begin
      if (st[0] != 0) m_sec = (m_sec + 1) % 60;
      if (st[1] != 0) m_min = (m_min + 1) % 60;
      if (st[2] != 0) m_hr  = (m_hr + 1) % 24;
    end else if (t1 && any_held == 0) begin
      m_sec = m_sec + 1;
      if (m_sec == 60) begin
        m_sec = 0; m_min = m_min + 1;
        if (m_min == 60) begin m_min = 0; m_hr = (m_hr + 1) % 24; end
      end
    end
    for (int i = 0; i < 3; i++) begin
      nxt = pressed[i];
      if (s_new[i] == 1 && s_old[i] == 1) nxt = 1;
      else if (s_new[i] == 0 && s_old[i] == 0) nxt = 0;
      if (pressed[i] != 0 && pressed_d[i] == 0) rep_ok[i] = 0;
      else if (pressed[i] != 0 && t8) rep_ok[i] = 1;
      pressed_d[i] = pressed[i];
      pressed[i] = nxt;
      if (sc) begin s_old[i] = s_new[i]; s_new[i] = ks[i]; end
    end
    cyc++;
  endtask

  task automatic run(input int n, input logic [2:0] k, input int scp, input int t8p, input int t1p);
    for (int j = 0; j < n; j++)
      cyc_once(k, scp != 0 && cyc % scp == 0, t8p != 0 && cyc % t8p == 0, t1p != 0 && cyc % t1p == 0);
  endtask

  task automatic tap(input logic [2:0] k);
    run(12, k, 4, 0, 0);
    run(12, 3'b000, 4, 0, 0);
  endtask

  task automatic direct(input string r, input logic [7:0] exp_h, input logic [7:0] exp_m, input logic [7:0] exp_s);
    @(negedge clk);
    vectors++;
    if (hr_bcd !== exp_h || min_bcd !== exp_m || sec_bcd !== exp_s) begin
      errors++;
      $display("FAIL %s direct: act %h:%h:%h exp %h:%h:%h", r, hr_bcd, min_bcd, sec_bcd, exp_h, exp_m, exp_s);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: act running exp finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    req = "R1"; run(4, 3'b000, 0, 0, 0);
    req = "R3"; run(150, 3'b000, 0, 0, 1);
    req = "R4"; run(4, 3'b010, 4, 0, 0); run(12, 3'b000, 4, 0, 0);
    req = "R5"; tap(3'b010); tap(3'b100);
    req = "R6"; run(200, 3'b100, 4, 8, 0); run(16, 3'b000, 4, 8, 0);
    req = "R9"; run(40, 3'b001, 4, 0, 1); run(16, 3'b000, 4, 0, 0);
    req = "R7"; run(520, 3'b001, 4, 8, 0); run(16, 3'b000, 4, 0, 0);
    req = "R8"; run(60, 3'b011, 4, 8, 0); run(16, 3'b000, 4, 8, 0);
    req = "R10"; tap(3'b111);
    @(negedge clk) rst = 1'b1;
    model_clear();
    @(negedge clk) rst = 1'b0;
    req = "R1"; direct("R1", 8'h00, 8'h00, 8'h00);
    req = "R2";
    for (int j = 0; j < 23; j++) tap(3'b100);
    for (int j = 0; j < 59; j++) tap(3'b010);
    for (int j = 0; j < 58; j++) tap(3'b001);
    direct("R2", 8'h23, 8'h59, 8'h58);
    req = "R3"; run(3, 3'b000, 0, 0, 1);
    direct("R3", 8'h00, 8'h00, 8'h01);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule